// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bit of a 32-bit multiplexed address/data bus with four active-low command/byte-enable lines. When the agent drives the bus, the block drives the parity line one clock later, so parity always trails the data it covers by exactly one cycle. When the agent receives, it compares the parity bit sampled in the following cycle with the parity it computed from the received bus value.

A mismatch on an address phase is a system-level error. It is reported by pulsing the shared system error line low for one clock, after which the line is released. A mismatch on a completed data phase is reported by the data receiver: the target on writes and the master on reads. It pulls the parity error line low for one clock, drives it high for one clock and then releases it. Two enable inputs decide whether each error kind reaches the bus. Detection and the sticky status flags do not depend on those enables.

All bus inputs are sampled on the rising clock edge. The active-low reset acts asynchronously.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `parOe` is 1, `parOut` equals the XOR of all bits of `adIn` and `cbeNIn` sampled at the previous rising edge, so those 36 bits plus `parOut` have even parity.
- R2: `parOe` equals `adOe` delayed by exactly one clock.
- R3: An address phase is a cycle with `frameN` low whose previous cycle had `frameN` high. If `adOe` is 0 in that cycle, the parity sampled on `parIn` in the next cycle is checked against the address/command bits.
- R4: A data phase is checked only when `irdyN` and `trdyN` are both low, the cycle is not an address phase, and the agent is the data receiver (`isMaster`=1 with `isWrite`=0, or `isMaster`=0 with `isWrite`=1). A bad parity bit in any other cycle causes no error.
- R5: A data parity error found on a transfer in cycle N, with `perrEn`=1, makes `perrOe`=1 and `perrNOut`=0 in cycle N+2, `perrOe`=1 and `perrNOut`=1 in cycle N+3, and `perrOe`=0 in cycle N+4.
- R6: An address parity error on an address phase in cycle N, with `serrEn`=1, makes `serrOe`=1 and `serrNOut`=0 in cycle N+2 only, and `serrOe`=0 in cycle N+3.
- R7: With `perrEn`=0 or `serrEn`=0, the matching error still sets `perrFlag` or `serrFlag` in cycle N+2, but the matching output enable stays 0.
- R8: Once set, `perrFlag` and `serrFlag` stay 1 until reset.
- R9: While `rstN` is low, `parOe`, `perrOe`, `serrOe`, `perrFlag` and `serrFlag` are all 0.
- R10: A data parity error never drives `serrOe`, and an address parity error never drives `perrOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 32 | Address/data bus as seen on the pins |
| cbeNIn | input | 4 | Command/byte-enable lines, active low |
| parIn | input | 1 | Parity line as seen on the pins |
| frameN | input | 1 | Transaction framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| isMaster | input | 1 | 1 when this agent is the initiator of the current transaction |
| isWrite | input | 1 | 1 for a write transaction, 0 for a read |
| adOe | input | 1 | 1 when this agent drives the address/data bus this cycle |
| perrEn | input | 1 | Allows data parity errors onto the parity error line |
| serrEn | input | 1 | Allows address parity errors onto the system error line |
| parOut | output | 1 | Generated parity bit |
| parOe | output | 1 | Output enable for the parity line |
| perrNOut | output | 1 | Parity error line value, active low |
| perrOe | output | 1 | Output enable for the parity error line |
| serrNOut | output | 1 | System error line value, active low |
| serrOe | output | 1 | Output enable for the system error line |
| perrFlag | output | 1 | Sticky status: a data parity error was detected |
| serrFlag | output | 1 | Sticky status: an address parity error was detected |

## Verification
The bench sweeps every combination of role, direction, ready-line pair, injected error and enable. This catches a design that swaps the receiver rule and flags errors on data it drove itself, or one that checks a cycle in which the transfer did not complete. Each error pulse is sampled cycle by cycle, so an off-by-one pipeline, a missing high cycle on the parity error line, or a system error held for two cycles each shows up as a wrong level or enable. Address phases are run with the agent both driving and not driving the bus, which catches an address error routed to the wrong line. Bus patterns of walking single bits plus arithmetic mixes expose a parity tree that drops a bit or loses the command lines.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Strobes from control to datapath: which check applies to this cycle.
  typedef struct packed {
    logic addrChk;
    logic dataChk;
  } chk_stb_t;

  // Mismatch results from datapath back to control.
  typedef struct packed {
    logic addrErr;
    logic dataErr;
  } par_err_t;

  typedef enum logic [1:0] {
    PERR_IDLE = 2'd0,
    PERR_LOW  = 2'd1,
    PERR_HIGH = 2'd2
  } perr_st_e;

endpackage

// File: rtl/pci_par_datapath.sv
module pci_par_datapath
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeNIn,
  input  logic             parIn,
  input  logic             adOe,
  input  chk_stb_t         chkStb,
  output logic             parOut,
  output logic             parOe,
  output par_err_t         parErr
);

  localparam int BUS_W = AD_W + CBE_W;

  logic [BUS_W-1:0] busVec;
  logic             busPar;
  logic             parQ;
  logic             parOeQ;
  chk_stb_t         chkQ;
  logic             mismatch;

  assign busVec = {adIn, cbeNIn};
  assign busPar = ^busVec;

  // One register holds the parity both for driving and for checking.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parQ   <= 1'b0;
      parOeQ <= 1'b0;
      chkQ   <= '0;
    end else begin
      parQ   <= busPar;
      parOeQ <= adOe;
      chkQ   <= chkStb;
    end
  end

  assign mismatch       = parIn ^ parQ;
  assign parErr.addrErr = chkQ.addrChk & mismatch;
  assign parErr.dataErr = chkQ.dataChk & mismatch;
  assign parOut         = parQ;
  assign parOe          = parOeQ;

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(parErr.addrErr && parErr.dataErr)); // R10

endmodule

// File: rtl/pci_par_control.sv
module pci_par_control
  import pci_par_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameN,
  input  logic     irdyN,
  input  logic     trdyN,
  input  logic     isMaster,
  input  logic     isWrite,
  input  logic     adOe,
  input  logic     perrEn,
  input  logic     serrEn,
  input  par_err_t parErr,
  output chk_stb_t chkStb,
  output logic     perrNOut,
  output logic     perrOe,
  output logic     serrNOut,
  output logic     serrOe,
  output logic     perrFlag,
  output logic     serrFlag
);

  logic     frameNQ;
  logic     addrPhase;
  logic     xferDone;
  logic     isReceiver;
  perr_st_e perrSt;
  perr_st_e perrNext;
  logic     serrQ;
  logic     perrFlagQ;
  logic     serrFlagQ;

  assign addrPhase  = !frameN && frameNQ;
  assign xferDone   = !irdyN && !trdyN;
  assign isReceiver = isMaster ^ isWrite;

  assign chkStb.addrChk = addrPhase && !adOe;
  assign chkStb.dataChk = xferDone && isReceiver && !addrPhase;

  always_comb begin
    perrNext = PERR_IDLE;
    if (parErr.dataErr && perrEn) begin
      perrNext = PERR_LOW;
    end else begin
      case (perrSt)
        PERR_LOW: perrNext = PERR_HIGH;
        default:  perrNext = PERR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameNQ   <= 1'b1;
      perrSt    <= PERR_IDLE;
      serrQ     <= 1'b0;
      perrFlagQ <= 1'b0;
      serrFlagQ <= 1'b0;
    end else begin
      frameNQ   <= frameN;
      perrSt    <= perrNext;
      serrQ     <= parErr.addrErr && serrEn;
      perrFlagQ <= perrFlagQ || parErr.dataErr;
      serrFlagQ <= serrFlagQ || parErr.addrErr;
    end
  end

  assign perrOe   = (perrSt != PERR_IDLE);
  assign perrNOut = (perrSt != PERR_LOW);
  assign serrOe   = serrQ;
  assign serrNOut = !serrQ;
  assign perrFlag = perrFlagQ;
  assign serrFlag = serrFlagQ;

  AST_PERR_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrNOut) |=> perrOe); // R5
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perrOe) |-> $past(perrEn)); // R7
  AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serrOe) |-> $past(serrEn)); // R7
  AST_SERR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> !serrNOut); // R6
  AST_PFLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    perrFlag |=> perrFlag); // R8
  AST_SFLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    serrFlag |=> serrFlag); // R8

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adIn,
  input  logic [CBE_W-1:0] cbeNIn,
  input  logic             parIn,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             isMaster,
  input  logic             isWrite,
  input  logic             adOe,
  input  logic             perrEn,
  input  logic             serrEn,
  output logic             parOut,
  output logic             parOe,
  output logic             perrNOut,
  output logic             perrOe,
  output logic             serrNOut,
  output logic             serrOe,
  output logic             perrFlag,
  output logic             serrFlag
);

  chk_stb_t chkStb;
  par_err_t parErr;

  pci_par_datapath #(.AD_W(AD_W), .CBE_W(CBE_W)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .adIn   (adIn),
    .cbeNIn (cbeNIn),
    .parIn  (parIn),
    .adOe   (adOe),
    .chkStb (chkStb),
    .parOut (parOut),
    .parOe  (parOe),
    .parErr (parErr)
  );

  pci_par_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .trdyN    (trdyN),
    .isMaster (isMaster),
    .isWrite  (isWrite),
    .adOe     (adOe),
    .perrEn   (perrEn),
    .serrEn   (serrEn),
    .parErr   (parErr),
    .chkStb   (chkStb),
    .perrNOut (perrNOut),
    .perrOe   (perrOe),
    .serrNOut (serrNOut),
    .serrOe   (serrOe),
    .perrFlag (perrFlag),
    .serrFlag (serrFlag)
  );

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ((^{$past(adIn), $past(cbeNIn)}) == parOut)); // R1
  AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rstN)
    adOe |=> parOe); // R2
  AST_NO_CROSS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !(perrOe && serrOe && !perrNOut && $rose(serrOe) && $rose(perrOe))); // R10

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!parOe && !perrOe && !serrOe && !perrFlag && !serrFlag); // R9
    end
  end

endmodule

// File: tb/test_pci_parity_unit.sv
`timescale 1ns/1ps
module test_pci_parity_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeNIn = '0;
  logic        parIn = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1;
  logic        isMaster = 1'b0, isWrite = 1'b0, adOe = 1'b0;
  logic        perrEn = 1'b0, serrEn = 1'b0;
  logic        parOut, parOe, perrNOut, perrOe, serrNOut, serrOe, perrFlag, serrFlag;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic prevCalc = 1'b0;

  always #4 clk = ~clk;

  pci_parity_unit i_pci_parity_unit (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeNIn(cbeNIn), .parIn(parIn),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN), .isMaster(isMaster),
    .isWrite(isWrite), .adOe(adOe), .perrEn(perrEn), .serrEn(serrEn),
    .parOut(parOut), .parOe(parOe), .perrNOut(perrNOut), .perrOe(perrOe),
    .serrNOut(serrNOut), .serrOe(serrOe), .perrFlag(perrFlag), .serrFlag(serrFlag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bus cycle; parIn carries the parity of the previous cycle,
  // optionally corrupted. Returns after the edge that ends this cycle.
  task automatic step(input logic [31:0] ad, input logic [3:0] cbe,
                      input logic fr, input logic ir, input logic tr, input logic bad);
    adIn   = ad;
    cbeNIn = cbe;
    frameN = fr;
    irdyN  = ir;
    trdyN  = tr;
    parIn  = prevCalc ^ bad;
    prevCalc = ^{ad, cbe};
    @(negedge clk);
  endtask

  task automatic idle();
    step(32'h0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    adOe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R9: quiet during reset
    check("R9 oe", {5'b0, parOe, perrOe, serrOe}, 8'h0);
    check("R9 flags", {6'b0, perrFlag, serrFlag}, 8'h0);
    rstN = 1'b1;
    idle();
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] ad;
    logic [3:0]  cbe;
    @(negedge clk);
    doReset();

    // R1/R2: parity generation over walking bits and mixed patterns
    adOe = 1'b1;
    for (int i = 0; i < 36; i++) begin
      {ad, cbe} = 36'h1 << i;
      step(ad, cbe, 1'b1, 1'b1, 1'b1, 1'b0);
      check("R2 parOe", {7'b0, parOe}, 8'h1);
      check("R1 walking", {7'b0, parOut}, 8'h1);
    end
    for (int i = 0; i < 200; i++) begin
      ad  = i * 32'h9E3779B1 ^ (32'h1 << (i % 32));
      cbe = i[3:0] ^ i[7:4];
      step(ad, cbe, 1'b1, 1'b1, 1'b1, 1'b0);
      check("R1 mixed", {7'b0, parOut}, {7'b0, ^{ad, cbe}});
    end
    adOe = 1'b0;
    step(32'h1, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R2 oe drop", {7'b0, parOe}, 8'h0);

    // Data phase sweep: R4, R5, R7, R10
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int rdy = 0; rdy < 4; rdy++)
          for (int e = 0; e < 2; e++)
            for (int en = 0; en < 2; en++) begin
              logic hit;
              doReset();
              isMaster = m[0];
              isWrite  = w[0];
              perrEn   = en[0];
              serrEn   = 1'b1;
              hit = (m[0] ^ w[0]) && (rdy == 0) && e[0];
              adOe = m[0];
              step(32'hA5A50000 + rdy, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0);
              adOe = (m[0] == w[0]);
              step(32'h0, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0);
              step(32'h1234_5678 ^ (m << 3) ^ (w << 9), 4'h3, 1'b0, rdy[0], rdy[1], 1'b0);
              adOe = 1'b0;
              step(32'h0, 4'hF, 1'b1, 1'b1, 1'b1, e[0]);
              // cycle N+2
              check("R5 low", {6'b0, perrOe, perrNOut}, (hit && en[0]) ? 8'h2 : 8'h1);
              check("R10 no serr", {7'b0, serrOe}, 8'h0);
              idle();
              check("R5 high", {6'b0, perrOe, perrNOut}, (hit && en[0]) ? 8'h3 : 8'h1);
              check("R7 perr flag", {7'b0, perrFlag}, {7'b0, hit});
              idle();
              check("R5 release", {7'b0, perrOe}, 8'h0);
              idle(); idle();
              check("R8 perr sticky", {7'b0, perrFlag}, {7'b0, hit});
              check("R10 no sflag", {7'b0, serrFlag}, 8'h0);
            end

    // Address phase sweep: R3, R6, R7, R10
    for (int drv = 0; drv < 2; drv++)
      for (int e = 0; e < 2; e++)
        for (int en = 0; en < 2; en++) begin
          logic hit;
          doReset();
          isMaster = drv[0];
          isWrite  = 1'b1;
          perrEn   = 1'b1;
          serrEn   = en[0];
          hit = !drv[0] && e[0];
          adOe = drv[0];
          step(32'hDEAD_0040, 4'h7, 1'b0, 1'b1, 1'b1, 1'b0);
          adOe = 1'b0;
          step(32'h0, 4'hF, 1'b0, 1'b1, 1'b1, e[0]);
          check("R6 low", {6'b0, serrOe, serrNOut}, (hit && en[0]) ? 8'h2 : 8'h1);
          check("R10 no perr", {7'b0, perrOe}, 8'h0);
          step(32'h0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0);
          check("R6 one clock", {7'b0, serrOe}, 8'h0);
          check("R3 flag", {7'b0, serrFlag}, {7'b0, hit});
          check("R10 no pflag", {7'b0, perrFlag}, 8'h0);
          idle(); idle();
          check("R8 serr sticky", {7'b0, serrFlag}, {7'b0, hit});
        end

    // R3: frame held low is not a new address phase
    doReset();
    serrEn = 1'b1;
    step(32'h11, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0);
    step(32'h22, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0);
    step(32'h0, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 no repeat phase", {6'b0, serrOe, serrFlag}, 8'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule